// File: doc/BRIEF.md
# Nibble ALU with Saved Carry

This block is a four-bit arithmetic and logic unit for a narrow datapath. It combines an A operand and a B operand under a three-bit operation code and drives a result bus without delay. Alongside the result it drives two combinational flags. The carry flag is the carry out of the arithmetic sum. The zero flag shows an all-zero result. The block also holds one latched saved-carry bit that the add-with-carry and rotate operations use.

A phase strobe sets when state is captured. On a clock edge where the strobe is high, the block loads the result into a result latch. On that same edge, the saved carry is rewritten if the operation code calls for it. On edges where the strobe is low, both latches hold.

Operation codes (binary): 000 gives A+B and 001 gives A+B+1, and neither touches the saved carry. 010 gives A+B, 011 gives A+B+saved carry and 100 gives A+B+1, and all three save their carry out. 101 gives A AND B and 110 gives A XOR B, and neither touches the saved carry. 111 adds A+B and rotates the five-bit sum right by one place through the saved carry.

Top module: `nibble_alu`

## Requirements
- R1: While rst_n is low, sc_q and z_q are 0. After reset is released they stay 0 until the first strobed edge.
- R2: Op 000 drives z = (A+B) mod 16 and op 001 drives z = (A+B+1) mod 16. A strobed edge with either op leaves sc_q unchanged.
- R3: Ops 010 and 100 drive z = A+B and A+B+1 (mod 16). A strobed edge with either op loads sc_q with the carry out of bit 3 of that sum.
- R4: Op 011 drives z = (A+B+sc_q) mod 16, using the sc_q held before the edge. A strobed edge loads sc_q with that sum's carry out of bit 3.
- R5: Op 101 drives z = A AND B and op 110 drives z = A XOR B. A strobed edge with either op leaves sc_q unchanged.
- R6: Op 111 forms the five-bit sum S = A+B, with no carry in. It drives z = S[4:1], so z3 is the carry out and z2..z0 are S[3:1]. A strobed edge loads sc_q with S[0].
- R7: zero is 1 exactly when all four bits of z are 0, for every op.
- R8: cc is the carry out of bit 3 of the arithmetic sum for every op. For 001 and 100 that sum includes +1, and for 011 it includes +sc_q. For 000, 010, 101, 110 and 111 the sum is plain A+B.
- R9: On a rising clock edge with stb high, z_q takes the z of that cycle. With stb low, z_q and sc_q both hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stb | input | 1 | Phase strobe; enables capture of z_q and sc_q |
| a_in | input | 4 | A operand |
| b_in | input | 4 | B operand |
| op | input | 3 | Operation code |
| z | output | 4 | Combinational result |
| cc | output | 1 | Combinational carry of the arithmetic sum |
| zero | output | 1 | Combinational zero flag of z |
| z_q | output | 4 | Result latched on strobe |
| sc_q | output | 1 | Saved carry flag |

## Verification
Two things can fall in the same cycle. Op 011 reads the saved carry as its carry in, while the same strobed edge overwrites that saved carry with the new carry out. Op 111 has the same overlap: its result uses the sum's carry while the edge replaces the saved bit. The bench provokes this with back-to-back strobed 011 and 111 operations on saturating operands such as F+1 and F+F. A behavioural model computes each step from the saved carry held before the edge. Results, flags and both latches are compared with that model on every cycle.

// File: rtl/nibble_alu.sv
module nibble_alu #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [2:0]   op,
  output logic [W-1:0] z,
  output logic         cc,
  output logic         zero,
  output logic [W-1:0] z_q,
  output logic         sc_q
);

  localparam logic [2:0] OP_ADD   = 3'b000;
  localparam logic [2:0] OP_INC   = 3'b001;
  localparam logic [2:0] OP_ADDS  = 3'b010;
  localparam logic [2:0] OP_ADC   = 3'b011;
  localparam logic [2:0] OP_INCS  = 3'b100;
  localparam logic [2:0] OP_AND   = 3'b101;
  localparam logic [2:0] OP_XOR   = 3'b110;
  localparam logic [2:0] OP_ROR   = 3'b111;

  logic         cin;
  logic [W:0]   sum;
  logic         sc_nxt;

  assign cin = (op == OP_INC || op == OP_INCS) ? 1'b1 :
               (op == OP_ADC) ? sc_q : 1'b0;

  assign sum  = {1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, cin};
  assign cc   = sum[W];
  assign zero = (z == '0);

  always_comb begin
    case (op)
      OP_AND:  z = a_in & b_in;
      OP_XOR:  z = a_in ^ b_in;
      OP_ROR:  z = sum[W:1];
      default: z = sum[W-1:0];
    endcase
  end

  always_comb begin
    case (op)
      OP_ADDS, OP_ADC, OP_INCS: sc_nxt = sum[W];
      OP_ROR:                   sc_nxt = sum[0];
      default:                  sc_nxt = sc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_q  <= '0;
      sc_q <= 1'b0;
    end else if (stb) begin
      z_q  <= z;
      sc_q <= sc_nxt;
    end
  end

  AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> ($stable(z_q) && $stable(sc_q))); // R9

  AST_ZQ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (z_q == $past(z))); // R9

  AST_SC_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && (op == OP_ADD || op == OP_INC || op == OP_AND || op == OP_XOR))
    |=> $stable(sc_q)); // R5

  AST_ROR_LOW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && op == OP_ROR) |=> (sc_q == $past(a_in[0] ^ b_in[0]))); // R6

  AST_ADDS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && op == OP_ADDS && a_in == '1 && b_in != '0) |=> sc_q); // R3

  AST_AND_DISJOINT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_AND && (a_in & b_in) == '0) |-> zero); // R7

endmodule

// File: tb/sim_nibble_alu.sv
`timescale 1ns/1ps
module sim_nibble_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0;
  logic [3:0] a_in = '0;
  logic [3:0] b_in = '0;
  logic [2:0] op = '0;
  logic [3:0] z, z_q;
  logic       cc, zero, sc_q;

  int n_cmp = 0;
  int n_bad = 0;
  int m_sc = 0;
  int m_zq = 0;
  bit done = 0;

  nibble_alu #(.W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .stb(stb), .a_in(a_in), .b_in(b_in), .op(op),
    .z(z), .cc(cc), .zero(zero), .z_q(z_q), .sc_q(sc_q)
  );

  always #2 clk = ~clk;

  task automatic cmp(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic string zreq(input int o);
    case (o)
      0, 1:    return "R2";
      2, 4:    return "R3";
      3:       return "R4";
      5, 6:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic step(input int a, input int b, input int o, input bit s);
    int sm, ez, ecc, nsc;
    @(negedge clk);
    cmp("R9 z_q", z_q, m_zq);
    cmp("R9 sc_q", sc_q, m_sc);
    a_in = a[3:0]; b_in = b[3:0]; op = o[2:0]; stb = s;
    #1;
    sm = a + b + ((o == 1 || o == 4) ? 1 : (o == 3) ? m_sc : 0);
    ecc = (sm >= 16) ? 1 : 0;
    nsc = m_sc;
    case (o)
      5: ez = a & b;
      6: ez = a ^ b;
      7: begin ez = sm / 2; nsc = sm % 2; end
      2, 3, 4: begin ez = sm % 16; nsc = ecc; end
      default: ez = sm % 16;
    endcase
    cmp(zreq(o), z, ez);
    cmp("R8 cc", cc, ecc);
    cmp("R7 zero", zero, (ez == 0) ? 1 : 0);
    @(posedge clk);
    #0.5;
    if (s) begin m_zq = ez; m_sc = nsc; end
  endtask

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cmp("R1 sc_q reset", sc_q, 0);
    cmp("R1 z_q reset", z_q, 0);
    @(negedge clk); rst_n = 1'b1;
    step(3, 4, 0, 0);
    cmp("R1 after release", sc_q, 0);
    // R3: overflow saves carry, then R4 chains it
    step(15, 1, 2, 1);
    step(0, 0, 3, 1);
    step(15, 15, 3, 1);
    step(15, 0, 3, 1);
    step(15, 1, 3, 1);
    // R2 / R5: SC must survive
    step(9, 9, 0, 1);
    step(15, 15, 1, 1);
    step(12, 3, 5, 1);
    step(10, 10, 6, 1);
    step(0, 0, 3, 1);
    // R6: rotate through SC
    step(15, 15, 7, 1);
    step(1, 0, 7, 1);
    step(0, 0, 3, 1);
    step(8, 8, 7, 1);
    step(7, 0, 4, 1);
    step(15, 0, 4, 1);
    // R9: no strobe holds latches
    step(15, 15, 2, 0);
    step(1, 2, 7, 0);
    step(5, 5, 6, 1);
    // R8: cc on logic ops reflects sum carry
    step(15, 15, 5, 0);
    step(8, 8, 6, 0);
    for (int i = 0; i < 600; i++)
      step($urandom_range(15), $urandom_range(15), $urandom_range(7), $urandom_range(1));
    @(negedge clk);
    cmp("R9 z_q final", z_q, m_zq);
    cmp("R9 sc_q final", sc_q, m_sc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule